// File: doc/BRIEF.md
# Programmable Chip-Select Decoder with Access Protection

This block turns every bus address into at most one chip-select for four external memory banks (A, B, C, D) on a 32-bit address bus. It can also flag a hit on the on-chip register block at the top of memory. Software programs the block through a small write port. Each bank has a 16-bit option word and a base address, and one control word is shared by all banks. A bank answers a window whose size comes from an exponential size code. The window is twice the bank's line size and starts at the bank's base address.

Banks B, C and D can protect the upper part of each line. The unprotected lower part is a programmable fraction of the line. Protected space can be limited to supervisor mode, made read-only, or both. Any bank can also be made read-only as a whole. A blocked access raises no chip-select. Instead it gives a one-cycle privilege-violation or write-protect pulse.

After reset bank A is in boot mode and answers the whole address space below the register block. It leaves boot mode the first time software enables it. Each access presented on the access inputs gives its registered result on the clock edge that samples it.

Top module: `csel_unit`

## Requirements
- R1: While reset is asserted, and until the first access after it, every output is low. All banks start disabled and bank A starts in boot mode.
- R2: Option word bit 0 enables a bank and bits 3:1 hold the size code k. The line size is 128 KiB·2^k for A and B and 32 KiB·2^k for C and D. A bank matches addresses in [base, base + 2·line).
- R3: The DRAM mode is active when control bit 6 and option-D bit 9 are both set. In that mode the line size of C and D is 8 MiB·2^(option bit 1). Bit 9 written to C's option word is discarded, so C follows D's bit only. Bits 9 and 10 of B and C are not stored.
- R4: Results are registered: an access sampled at a clock edge is reflected on the outputs right after that edge. `sel_o` is one-hot, with bit i for bank i (A=0 … D=3). All outputs are low when `acc_valid` is low or no window matches.
- R5: Priority is fixed. An address at or above 0xFFFFF000 gives only `reg_hit_o`. Below that, A beats B, B beats C and C beats D.
- R6: Bank A stays in boot mode, matching every address below 0xFFFFF000, until a write to A's option word with bit 0 set. A write with bit 0 clear leaves boot mode on.
- R7: For B, C and D the unprotected size is line/2^(7−p). The value p takes bits 12:11 as its low two bits. Its bit 2 is set when control bit 14 is set together with that bank's control bit (bit 0 for B, bit 2 for C, bit 4 for D). The offset is taken modulo the line size, so both halves of a window behave alike.
- R8: An access to B, C or D is a privilege violation when its offset is in the protected part, option bit 14 is set and `acc_super` is low. This applies to reads and to writes. The access gives a `priv_viol_o` pulse and no chip-select.
- R9: A write gives a `wp_viol_o` pulse and no chip-select in two cases: option bit 15 is set, or the write lands in the protected part with option bit 13 set and no privilege violation. Bit 15 is checked first. Reads are not affected by bits 15 and 13.
- R10: A configuration write changes decoding for accesses sampled from the next edge on. An access in the same cycle still sees the old settings. A change of control bits 0, 2, 4, 6 or 14, or of D's bit 9, takes effect on the affected banks without rewriting them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Slot: 0–3 option A–D, 4 control, 8–11 base A–D |
| cfg_wdata | input | 32 | Write data (options and control use bits 15:0) |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_super | input | 1 | CPU in supervisor mode |
| sel_o | output | 4 | One-hot chip-selects, bit 0 = A |
| reg_hit_o | output | 1 | Register-block hit |
| priv_viol_o | output | 1 | Privilege violation pulse |
| wp_viol_o | output | 1 | Write-protect violation pulse |

## Verification
Every decode result is due on the first clock edge that samples its access, so it is visible at the falling edge that follows. A configuration write changes results one edge later. The bench's reference model mirrors both timings: at each rising edge it evaluates the pending access against its own copy of the registers before applying a pending write. The comparison is made at the next falling edge, when the outputs have settled. Directed sequences place a write and an access in the same cycle so that the one-edge delay on configuration changes is covered.

// File: rtl/csu_pkg.sv
package csu_pkg;
   localparam int NUM_SEL  = 4;
   localparam int CFG_AW   = 4;
   localparam int OPT_W    = 16;

   // option word fields
   localparam int OPT_EN    = 0;
   localparam int OPT_SZ_LO = 1;
   localparam int OPT_DRAM  = 9;
   localparam int OPT_P_LO  = 11;
   localparam int OPT_PRO   = 13;
   localparam int OPT_SUP   = 14;
   localparam int OPT_RO    = 15;

   // control word fields
   localparam int CTL_DRAM  = 6;
   localparam int CTL_WIDE  = 14;
   localparam logic [OPT_W-1:0] CTL_MASK = 16'h7F55;

   // configuration slots
   localparam logic [CFG_AW-1:0] SLOT_CTL  = 4'd4;
   localparam logic [CFG_AW-1:0] SLOT_BASE = 4'd8;

   function automatic logic [OPT_W-1:0] opt_store_mask(input int idx);
      return (idx == 1 || idx == 2) ? 16'hF9FF : 16'hFFFF;
   endfunction

   // control bit that widens the protection fraction of bank idx
   function automatic int prot_ctl_bit(input int idx);
      return (idx > 0) ? 2 * (idx - 1) : 0;
   endfunction
endpackage

// File: rtl/csu_regs.sv
module csu_regs
   import csu_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           cfg_we,
   input  logic [CFG_AW-1:0]              cfg_addr,
   input  logic [31:0]                    cfg_wdata,
   output logic [NUM_SEL-1:0][OPT_W-1:0]  opt_q,
   output logic [NUM_SEL-1:0][ADDR_W-1:0] base_q,
   output logic [OPT_W-1:0]               ctl_q,
   output logic                           boot_q
);
   localparam int DATA_KEEP = (ADDR_W < 32) ? ADDR_W : 32;

   generate
      for (genvar i = 0; i < NUM_SEL; i++) begin : g_slot
         localparam logic [CFG_AW-1:0] OPT_SLOT  = CFG_AW'(i);
         localparam logic [CFG_AW-1:0] BASE_SLOT = SLOT_BASE + CFG_AW'(i);
         localparam logic [OPT_W-1:0]  KEEP      = opt_store_mask(i);
         logic [OPT_W-1:0]  opt_r;
         logic [ADDR_W-1:0] base_r;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               opt_r  <= '0;
               base_r <= '0;
            end else if (cfg_we) begin
               if (cfg_addr == OPT_SLOT)
                  opt_r <= cfg_wdata[OPT_W-1:0] & KEEP;
               if (cfg_addr == BASE_SLOT)
                  base_r <= ADDR_W'(cfg_wdata[DATA_KEEP-1:0]);
            end
         end

         assign opt_q[i]  = opt_r;
         assign base_q[i] = base_r;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         boot_q <= 1'b1;
      end else if (cfg_we) begin
         if (cfg_addr == SLOT_CTL)
            ctl_q <= cfg_wdata[OPT_W-1:0] & CTL_MASK;
         if (cfg_addr == '0 && cfg_wdata[OPT_EN])
            boot_q <= 1'b0;
      end
   end

   // R6
   boot_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(boot_q) |-> $past(cfg_we && cfg_addr == '0 && cfg_wdata[OPT_EN]));
endmodule

// File: rtl/csu_bank.sv
module csu_bank
   import csu_pkg::*;
#(
   parameter int ADDR_W         = 32,
   parameter int LINE_LOG2_MIN  = 17,
   parameter bit DRAM_CAPABLE   = 1'b0,
   parameter int DRAM_LOG2      = 23,
   parameter bit HAS_PROT       = 1'b0,
   parameter int PROT_DIV_LOG2  = 7,
   parameter int PROT_CTL_BIT   = 0
) (
   input  logic [OPT_W-1:0]  opt,
   input  logic [OPT_W-1:0]  ctl,
   input  logic              dram_d,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] addr,
   input  logic              force_all,
   output logic              hit,
   output logic              in_prot,
   output logic              ro_all,
   output logic              sup_only,
   output logic              ro_prot
);
   localparam int LOG_W = $clog2(ADDR_W) + 1;

   logic [LOG_W-1:0]  line_log2;
   logic [LOG_W-1:0]  win_log2;
   logic [ADDR_W-1:0] win_keep;
   logic [2:0]        code;

   assign code = opt[OPT_SZ_LO +: 3];

   generate
      if (DRAM_CAPABLE) begin : g_dram
         logic dram_mode;
         assign dram_mode = ctl[CTL_DRAM] & dram_d;
         assign line_log2 = dram_mode
            ? LOG_W'(DRAM_LOG2) + LOG_W'(opt[OPT_SZ_LO])
            : LOG_W'(LINE_LOG2_MIN) + LOG_W'(code);
      end else begin : g_plain
         assign line_log2 = LOG_W'(LINE_LOG2_MIN) + LOG_W'(code);
      end
   endgenerate

   assign win_log2 = line_log2 + LOG_W'(1);
   assign win_keep = {ADDR_W{1'b1}} << win_log2;
   assign hit      = force_all |
                     (opt[OPT_EN] & (((addr ^ base) & win_keep) == '0));
   assign ro_all   = opt[OPT_RO];

   generate
      if (HAS_PROT) begin : g_prot
         logic [2:0]        p;
         logic [LOG_W-1:0]  unp_log2;
         logic [ADDR_W-1:0] line_off;

         assign p        = {ctl[CTL_WIDE] & ctl[PROT_CTL_BIT], opt[OPT_P_LO +: 2]};
         assign unp_log2 = line_log2 - LOG_W'(PROT_DIV_LOG2) + LOG_W'(p);
         assign line_off = addr & ~({ADDR_W{1'b1}} << line_log2);
         assign in_prot  = (line_off >> unp_log2) != '0;
         assign sup_only = opt[OPT_SUP];
         assign ro_prot  = opt[OPT_PRO];
      end else begin : g_noprot
         assign in_prot  = 1'b0;
         assign sup_only = 1'b0;
         assign ro_prot  = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/csu_arb.sv
module csu_arb
   import csu_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_valid,
   input  logic               acc_write,
   input  logic               acc_super,
   input  logic               reg_raw,
   input  logic [NUM_SEL-1:0] hit,
   input  logic [NUM_SEL-1:0] in_prot,
   input  logic [NUM_SEL-1:0] ro_all,
   input  logic [NUM_SEL-1:0] sup_only,
   input  logic [NUM_SEL-1:0] ro_prot,
   output logic [NUM_SEL-1:0] sel_o,
   output logic               reg_hit_o,
   output logic               priv_viol_o,
   output logic               wp_viol_o
);
   logic [NUM_SEL-1:0] win;
   logic               found;
   logic [NUM_SEL-1:0] sel_n;
   logic               reg_n, pv_n, wp_n;
   logic               w_ro, w_prot, w_sup, w_rop;

   always_comb begin
      win   = '0;
      found = 1'b0;
      for (int i = 0; i < NUM_SEL; i++) begin
         if (!found && hit[i]) begin
            win[i] = 1'b1;
            found  = 1'b1;
         end
      end
   end

   assign w_ro   = |(win & ro_all);
   assign w_prot = |(win & in_prot);
   assign w_sup  = |(win & sup_only);
   assign w_rop  = |(win & ro_prot);

   always_comb begin
      sel_n = '0;
      reg_n = 1'b0;
      pv_n  = 1'b0;
      wp_n  = 1'b0;
      if (acc_valid) begin
         if (reg_raw)
            reg_n = 1'b1;
         else if (found) begin
            if (acc_write && w_ro)
               wp_n = 1'b1;
            else if (w_prot && w_sup && !acc_super)
               pv_n = 1'b1;
            else if (acc_write && w_prot && w_rop)
               wp_n = 1'b1;
            else
               sel_n = win;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_o       <= '0;
         reg_hit_o   <= 1'b0;
         priv_viol_o <= 1'b0;
         wp_viol_o   <= 1'b0;
      end else begin
         sel_o       <= sel_n;
         reg_hit_o   <= reg_n;
         priv_viol_o <= pv_n;
         wp_viol_o   <= wp_n;
      end
   end

   // R4
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_o));
   // R4
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> (sel_o == '0 && !reg_hit_o && !priv_viol_o && !wp_viol_o));
   // R5
   reg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_hit_o |-> (sel_o == '0 && !priv_viol_o && !wp_viol_o));
   // R8
   priv_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
      priv_viol_o |-> ($past(!acc_super) && sel_o == '0 && !wp_viol_o));
   // R9
   wp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wp_viol_o |-> ($past(acc_write) && sel_o == '0));
endmodule

// File: rtl/csel_unit.sv
module csel_unit
   import csu_pkg::*;
#(
   parameter int               ADDR_W        = 32,
   parameter logic [31:0]      REG_BASE      = 32'hFFFF_F000,
   parameter int               WIDE_LOG2     = 17,
   parameter int               NARROW_LOG2   = 15,
   parameter int               DRAM_LOG2     = 23,
   parameter int               PROT_DIV_LOG2 = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [3:0]         cfg_addr,
   input  logic [31:0]        cfg_wdata,
   input  logic               acc_valid,
   input  logic [ADDR_W-1:0]  acc_addr,
   input  logic               acc_write,
   input  logic               acc_super,
   output logic [3:0]         sel_o,
   output logic               reg_hit_o,
   output logic               priv_viol_o,
   output logic               wp_viol_o
);
   generate
      if (ADDR_W < DRAM_LOG2 + 2) begin : g_bad_dram
         $error("ADDR_W too small for the DRAM window");
      end
      if (ADDR_W < WIDE_LOG2 + 8) begin : g_bad_wide
         $error("ADDR_W too small for the largest size code");
      end
      if (NARROW_LOG2 < PROT_DIV_LOG2 || WIDE_LOG2 < PROT_DIV_LOG2) begin : g_bad_div
         $error("protection divider exceeds the smallest line");
      end
   endgenerate

   logic [NUM_SEL-1:0][OPT_W-1:0]  opt_q;
   logic [NUM_SEL-1:0][ADDR_W-1:0] base_q;
   logic [OPT_W-1:0]               ctl_q;
   logic                           boot_q;
   logic [NUM_SEL-1:0]             hit, in_prot, ro_all, sup_only, ro_prot;
   logic                           reg_raw;

   csu_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .opt_q(opt_q), .base_q(base_q),
      .ctl_q(ctl_q), .boot_q(boot_q)
   );

   generate
      for (genvar i = 0; i < NUM_SEL; i++) begin : g_bank
         csu_bank #(
            .ADDR_W       (ADDR_W),
            .LINE_LOG2_MIN((i < 2) ? WIDE_LOG2 : NARROW_LOG2),
            .DRAM_CAPABLE (i >= 2),
            .DRAM_LOG2    (DRAM_LOG2),
            .HAS_PROT     (i > 0),
            .PROT_DIV_LOG2(PROT_DIV_LOG2),
            .PROT_CTL_BIT (prot_ctl_bit(i))
         ) u_bank (
            .opt      (opt_q[i]),
            .ctl      (ctl_q),
            .dram_d   (opt_q[NUM_SEL-1][OPT_DRAM]),
            .base     (base_q[i]),
            .addr     (acc_addr),
            .force_all((i == 0) ? boot_q : 1'b0),
            .hit      (hit[i]),
            .in_prot  (in_prot[i]),
            .ro_all   (ro_all[i]),
            .sup_only (sup_only[i]),
            .ro_prot  (ro_prot[i])
         );
      end
   endgenerate

   assign reg_raw = acc_addr >= ADDR_W'(REG_BASE);

   csu_arb u_arb (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_super(acc_super), .reg_raw(reg_raw), .hit(hit), .in_prot(in_prot),
      .ro_all(ro_all), .sup_only(sup_only), .ro_prot(ro_prot),
      .sel_o(sel_o), .reg_hit_o(reg_hit_o), .priv_viol_o(priv_viol_o),
      .wp_viol_o(wp_viol_o)
   );
endmodule

// File: tb/tb_csel_unit.sv
module tb_csel_unit;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        acc_write = 1'b0;
   logic        acc_super = 1'b0;
   logic [3:0]  sel_o;
   logic        reg_hit_o, priv_viol_o, wp_viol_o;

   int    n_tests = 0;
   int    n_fail  = 0;
   bit    checking = 1'b0;
   bit    done = 1'b0;
   string cur_tag = "R1";
   int    cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   csel_unit dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_write(acc_write), .acc_super(acc_super), .sel_o(sel_o),
      .reg_hit_o(reg_hit_o), .priv_viol_o(priv_viol_o), .wp_viol_o(wp_viol_o)
   );

   // reference model state
   logic [15:0] m_opt [4];
   logic [15:0] m_ctl;
   logic [31:0] m_base [4];
   bit          m_boot;
   logic [3:0]  e_sel;
   bit          e_reg, e_pv, e_wp;

   function automatic longint line_of(int i);
      if (i >= 2 && m_ctl[6] && m_opt[3][9])
         return 64'h80_0000 << m_opt[i][1];
      return ((i < 2) ? 64'h2_0000 : 64'h8000) << m_opt[i][3:1];
   endfunction

   task automatic model_eval();
      longint a, ln, unp, off;
      int win, p;
      bit prot;
      e_sel = '0; e_reg = 0; e_pv = 0; e_wp = 0;
      if (!acc_valid) return;
      a = longint'(acc_addr);
      if (a >= 64'hFFFF_F000) begin e_reg = 1; return; end
      win = -1;
      for (int i = 3; i >= 0; i--) begin
         ln = line_of(i);
         if ((i == 0 && m_boot) ||
             (m_opt[i][0] && a >= longint'(m_base[i]) && a < longint'(m_base[i]) + 2*ln))
            win = i;
      end
      if (win < 0) return;
      ln = line_of(win);
      prot = 0;
      if (win > 0) begin
         p = int'(m_opt[win][12:11]);
         if (m_ctl[14] && m_ctl[2*(win-1)]) p = p + 4;
         unp = ln >> (7 - p);
         off = (a - longint'(m_base[win])) % ln;
         prot = off >= unp;
      end
      if (acc_write && m_opt[win][15]) e_wp = 1;
      else if (win > 0 && prot && m_opt[win][14] && !acc_super) e_pv = 1;
      else if (win > 0 && acc_write && prot && m_opt[win][13]) e_wp = 1;
      else e_sel[win] = 1'b1;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) begin m_opt[i] = '0; m_base[i] = '0; end
         m_ctl = '0; m_boot = 1; e_sel = '0; e_reg = 0; e_pv = 0; e_wp = 0;
      end else begin
         model_eval();
         if (cfg_we) begin
            if (cfg_addr < 4)
               m_opt[cfg_addr] = cfg_wdata[15:0] &
                  ((cfg_addr == 1 || cfg_addr == 2) ? 16'hF9FF : 16'hFFFF);
            if (cfg_addr == 4) m_ctl = cfg_wdata[15:0] & 16'h7F55;
            if (cfg_addr >= 8 && cfg_addr < 12) m_base[cfg_addr-8] = cfg_wdata;
            if (cfg_addr == 0 && cfg_wdata[0]) m_boot = 0;
         end
      end
   end

   always @(negedge clk) begin
      if (checking && !done) begin
         n_tests++;
         if (sel_o !== e_sel || reg_hit_o !== e_reg ||
             priv_viol_o !== e_pv || wp_viol_o !== e_wp) begin
            n_fail++;
            $display("FAIL %s addr=%h: got sel=%b reg=%b pv=%b wp=%b exp sel=%b reg=%b pv=%b wp=%b",
                     cur_tag, acc_addr, sel_o, reg_hit_o, priv_viol_o, wp_viol_o,
                     e_sel, e_reg, e_pv, e_wp);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000 && !done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic cfg(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1; cfg_addr = a; cfg_wdata = d; acc_valid = 0;
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic acc(input logic [31:0] a, input bit w, input bit s);
      @(negedge clk);
      cfg_we = 0; acc_valid = 1; acc_addr = a; acc_write = w; acc_super = s;
      @(negedge clk);
      acc_valid = 0;
   endtask

   initial begin
      #1 rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      checking = 1;
      // R1 reset state checked by the negedge comparison
      @(negedge clk);
      cur_tag = "R1";
      n_tests++;
      if (sel_o !== 4'b0 || reg_hit_o || priv_viol_o || wp_viol_o) begin
         n_fail++;
         $display("FAIL R1 reset outputs got %b exp 0000", sel_o);
      end
      cur_tag = "R6"; acc(32'h0000_1234, 0, 0); acc(32'h8000_0000, 1, 0);
      cur_tag = "R5"; acc(32'hFFFF_F000, 0, 1); acc(32'hFFFF_FFFC, 1, 0);
      acc(32'hFFFF_EFFF, 0, 0);
      cur_tag = "R6"; cfg(4'd0, 32'h0002); acc(32'h5000_0000, 0, 0);
      cur_tag = "R2"; cfg(4'd8, 32'h1000_0000); cfg(4'd0, 32'h0003);
      acc(32'h1000_0000, 0, 0); acc(32'h1007_FFFF, 1, 0); acc(32'h1008_0000, 0, 0);
      acc(32'h5000_0000, 0, 0);
      cur_tag = "R8"; cfg(4'd9, 32'h2000_0000); cfg(4'd1, 32'h5001);
      acc(32'h2000_0100, 0, 0); acc(32'h2000_1000, 0, 0); acc(32'h2000_1000, 1, 0);
      acc(32'h2000_1000, 0, 1);
      cur_tag = "R7"; acc(32'h2002_0100, 0, 0); acc(32'h2002_1000, 0, 0);
      acc(32'h2004_0000, 0, 0);
      cur_tag = "R9"; cfg(4'd1, 32'h3001);
      acc(32'h2000_2000, 1, 1); acc(32'h2000_0010, 1, 0); acc(32'h2000_2000, 0, 0);
      cur_tag = "R2"; cfg(4'd10, 32'h3000_0000); cfg(4'd2, 32'h0005);
      acc(32'h3003_0000, 0, 0); acc(32'h3010_0000, 0, 0);
      cur_tag = "R3"; cfg(4'd2, 32'h0205); cfg(4'd4, 32'h0040);
      acc(32'h3010_0000, 0, 0);
      cfg(4'd11, 32'h4000_0000); cfg(4'd3, 32'h0201);
      acc(32'h3010_0000, 0, 0); acc(32'h40FF_FFFF, 0, 0); acc(32'h4100_0000, 0, 0);
      cur_tag = "R7"; cfg(4'd2, 32'h4005);
      acc(32'h3001_0000, 0, 0);
      cur_tag = "R10"; cfg(4'd4, 32'h4044);
      acc(32'h3001_0000, 0, 0); acc(32'h3010_0000, 0, 0); acc(32'h3010_0000, 1, 1);
      cur_tag = "R9"; cfg(4'd3, 32'h8201);
      acc(32'h4000_0000, 1, 1); acc(32'h4000_0000, 0, 0);
      cur_tag = "R10";
      @(negedge clk);
      cfg_we = 1; cfg_addr = 4'd3; cfg_wdata = 32'h0001;
      acc_valid = 1; acc_addr = 32'h3010_0000; acc_write = 0; acc_super = 0;
      @(negedge clk);
      cfg_we = 0; acc_addr = 32'h3010_0000;
      @(negedge clk);
      acc_valid = 0;
      cur_tag = "R5"; cfg(4'd9, 32'h1000_0000); cfg(4'd1, 32'h0001);
      acc(32'h1000_0000, 0, 0);
      cfg(4'd0, 32'h0000); acc(32'h1000_0000, 0, 0);
      cur_tag = "R4";
      for (int k = 0; k < 300; k++) begin
         logic [31:0] r;
         logic [31:0] bases [6];
         bases = '{32'h1000_0000, 32'h3000_0000, 32'h4000_0000,
                   32'h3080_0000, 32'hFFFF_E000, 32'h2000_0000};
         r = $urandom;
         @(negedge clk);
         acc_valid = r[31];
         acc_addr = bases[r[2:0] % 6] + (r & 32'h00FF_FFF0);
         acc_write = r[4]; acc_super = r[5];
         if (r[30:27] == 4'hF) begin
            cfg_we = 1; cfg_addr = 4'd4; cfg_wdata = {16'h0, r[22:7]};
         end else cfg_we = 0;
      end
      @(negedge clk);
      acc_valid = 0; cfg_we = 0;
      @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule